// File: doc/BRIEF.md
# Dual-Phase Framed Serial Transmitter

This block turns parallel words into a serial bitstream that is locked to an external frame sync. Words are written into a small first-in first-out store. Each detected frame-sync edge starts one frame. A frame holds either one phase or two. Each phase has its own number of elements and its own element width. After an optional lead-in of up to three bit slots, the elements are sent most-significant bit first on one selected edge of the bit clock.

All logic runs on the system clock `clk_i`. The bit clock and the frame sync are sampled as ordinary inputs, and a launch tick is formed on the selected edge of `bclk_i`. The frame sync is sampled only on launch ticks. If the store runs dry, the block still keeps the frame timing: it sends zeros in place of the missing word and flags the gap. A frame-sync edge that arrives in the middle of a frame is reported and otherwise discarded. A frame-sync edge that lands on the tick just after the last bit of a frame starts the next frame with no gap. This allows continuous back-to-back streams.

Top module: `dpf_serializer`

## Requirements
- R1: When `dual_phase_i` is 0, a frame holds the phase-one elements only. When it is 1, the phase-two elements follow the phase-one elements directly, with no idle slot between them.
- R2: The element count of a phase equals its 6-bit count field plus one. Field value 63 gives 64 elements.
- R3: The width code of a phase selects the element width: code 0 gives 8 bits, 1 gives 10, 2 gives 12, 3 gives 14, 4 gives 16, 5 gives 20, 6 gives 24 and 7 gives 32.
- R4: Each element takes the low N bits of one stored word, where N is the element width, and sends them most-significant bit first, one bit per launch tick.
- R5: Call the launch tick on which the frame-sync edge is seen tick 0. The first data bit is driven on tick D, where D is `delay_i` (0 to 3). `sd_o` is 0 while idle and during the lead-in.
- R6: `launch_fall_i` = 0 launches on rising edges of `bclk_i` and 1 launches on falling edges. `fs_low_i` = 0 makes the frame sync active high and 1 makes it active low. A frame starts when the sampled sync goes from inactive to active between two launch ticks.
- R7: `busy_o` rises on the frame-start tick and stays 1 through the slot of the last bit. On the next launch tick it returns to 0 and `sd_o` returns to 0, unless a new frame starts on that tick.
- R8: The store holds FIFO_DEPTH words. `fifo_full_o` and `fifo_empty_o` report its fill level. A write while it is full is discarded.
- R9: If an element must be loaded while the store is empty, `underrun_o` pulses for one clock, the element is sent as all zeros at full length, and the frame length does not change.
- R10: A frame-sync edge during the lead-in or during data bits pulses `fs_err_o` for one clock and leaves the frame unchanged. A frame-sync edge on the tick just after the last bit starts a new frame and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock, sampled by clk_i |
| fs_i | input | 1 | Frame sync |
| wr_en_i | input | 1 | Write strobe into the word store |
| wr_data_i | input | WORD_W | Word to store |
| dual_phase_i | input | 1 | 1 = two phases per frame |
| p1_count_i | input | FLEN_W | Phase-one element count minus one |
| p2_count_i | input | FLEN_W | Phase-two element count minus one |
| p1_width_i | input | 3 | Phase-one element width code |
| p2_width_i | input | 3 | Phase-two element width code |
| delay_i | input | 2 | Lead-in slots after the frame-sync edge |
| launch_fall_i | input | 1 | 1 = launch on falling bit-clock edge |
| fs_low_i | input | 1 | 1 = frame sync active low |
| sd_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |
| fifo_empty_o | output | 1 | Word store empty |
| fifo_full_o | output | 1 | Word store full |
| underrun_o | output | 1 | One-clock pulse: element loaded from empty store |
| fs_err_o | output | 1 | One-clock pulse: frame-sync edge inside a frame |

## Verification
The bench targets these corner cases:
- **Phase hand-over in the fixed 1×16 plus 12×20 shape.** An off-by-one there would drop or repeat an element, or switch widths one element late.
- **A frame of 64 narrow elements fed from a store that empties after 16.** A design that stalls or skips on a gap would shorten the frame instead of sending zeros.
- **The full delay range, with both launch edges and both sync polarities.** A wrong lead-in would shift the whole stream by a slot.
- **A sync pulse in mid-frame and a sync pulse on the tick right after the last bit.** A design that mishandles the first would restart and corrupt the frame. A design that mishandles the second would report a false error and lose a whole back-to-back frame.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

    localparam int ELEM_MAX = 32;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_SHIFT = 2'd2
    } frm_state_e;

    // width code to element length in bits
    function automatic logic [5:0] elem_bits(input logic [2:0] code);
        logic [5:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd10;
            3'd2:    n = 6'd12;
            3'd3:    n = 6'd14;
            3'd4:    n = 6'd16;
            3'd5:    n = 6'd20;
            3'd6:    n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dpf_edge.sv
module dpf_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    input  logic fs_i,
    input  logic launch_fall_i,
    input  logic fs_low_i,
    output logic tick_o,
    output logic fs_edge_o
);

    typedef struct packed {
        logic bclk;
        logic fs_prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     fs_act;

    always_comb begin
        st_d      = st_q;
        st_d.bclk = bclk_i;
        fs_act    = fs_i ^ fs_low_i;
        tick_o    = launch_fall_i ? (st_q.bclk & ~bclk_i) : (~st_q.bclk & bclk_i);
        fs_edge_o = tick_o & fs_act & ~st_q.fs_prev;
        if (tick_o) begin
            st_d.fs_prev = fs_act;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: one bit-clock edge never yields two consecutive launch ticks
    a_r6_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dpf_fifo.sv
module dpf_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             push, pop;

    assign full_o    = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o   = (st_q.cnt == '0);
    assign rd_data_o = mem_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        push = wr_i && !full_o;
        pop  = rd_i && !empty_o;
        if (push) begin
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + PTR_W'(1);
        end
        if (pop) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (push) begin
            mem_q[st_q.wp] <= wr_data_i;
        end
    end

    // R8: a write into a full store with no read leaves the level unchanged
    a_r8_full_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && wr_i && !rd_i) |=> $stable(st_q.cnt));

    // R8: an accepted write with no read raises the level by one
    a_r8_write_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !full_o && !rd_i) |=> (st_q.cnt == $past(st_q.cnt) + CNT_W'(1)));

endmodule

// File: rtl/dpf_framer.sv
module dpf_framer
    import dpf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FLEN_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              fs_edge_i,
    input  logic              dual_i,
    input  logic [FLEN_W-1:0] cnt1_i,
    input  logic [FLEN_W-1:0] cnt2_i,
    input  logic [2:0]        wid1_i,
    input  logic [2:0]        wid2_i,
    input  logic [1:0]        delay_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    input  logic              fifo_empty_i,
    output logic              pop_o,
    output logic              sd_o,
    output logic              busy_o,
    output logic              underrun_o,
    output logic              fs_err_o
);

    localparam int ECNT_W = FLEN_W + 1;
    localparam int BIT_W  = $clog2(ELEM_MAX);

    typedef struct packed {
        frm_state_e          state;
        logic                phase;
        logic [ECNT_W-1:0]   elem_left;
        logic [BIT_W-1:0]    bits_left;
        logic [ELEM_MAX-1:0] sh;
        logic [1:0]          dly;
        logic                sd;
        logic                udr;
        logic                fserr;
    } frm_st_t;

    localparam frm_st_t RST_VAL = '{state: S_IDLE, default: '0};

    frm_st_t             st_d, st_q;
    logic                go, begin_frame, finishing;
    logic [5:0]          len;
    logic [ELEM_MAX-1:0] word, aligned;

    always_comb begin
        st_d        = st_q;
        st_d.udr    = 1'b0;
        st_d.fserr  = 1'b0;
        pop_o       = 1'b0;
        go          = 1'b0;
        begin_frame = 1'b0;
        len         = '0;
        word        = '0;
        aligned     = '0;
        finishing   = (st_q.bits_left == '0) && (st_q.elem_left == '0)
                      && !(!st_q.phase && dual_i);

        if (tick_i) begin
            case (st_q.state)
                S_IDLE: begin
                    if (fs_edge_i) begin
                        begin_frame = 1'b1;
                    end
                end
                S_DELAY: begin
                    if (fs_edge_i) begin
                        st_d.fserr = 1'b1;
                    end
                    if (st_q.dly == '0) begin
                        go = 1'b1;
                    end else begin
                        st_d.dly = st_q.dly - 2'd1;
                    end
                end
                S_SHIFT: begin
                    if (finishing) begin
                        if (fs_edge_i) begin
                            begin_frame = 1'b1;
                        end else begin
                            st_d.state = S_IDLE;
                            st_d.sd    = 1'b0;
                        end
                    end else begin
                        if (fs_edge_i) begin
                            st_d.fserr = 1'b1;
                        end
                        go = 1'b1;
                    end
                end
                default: st_d.state = S_IDLE;
            endcase
        end

        if (begin_frame) begin
            st_d.phase     = 1'b0;
            st_d.elem_left = {1'b0, cnt1_i} + ECNT_W'(1);
            st_d.bits_left = '0;
            st_d.sd        = 1'b0;
            if (delay_i == 2'd0) begin
                go = 1'b1;
            end else begin
                st_d.state = S_DELAY;
                st_d.dly   = delay_i - 2'd1;
            end
        end

        if (go) begin
            st_d.state = S_SHIFT;
            if (st_d.bits_left != '0) begin
                st_d.sd        = st_d.sh[ELEM_MAX-1];
                st_d.sh        = st_d.sh << 1;
                st_d.bits_left = st_d.bits_left - BIT_W'(1);
            end else begin
                if (st_d.elem_left == '0) begin
                    st_d.phase     = 1'b1;
                    st_d.elem_left = {1'b0, cnt2_i} + ECNT_W'(1);
                end
                st_d.elem_left = st_d.elem_left - ECNT_W'(1);
                pop_o          = !fifo_empty_i;
                st_d.udr       = fifo_empty_i;
                word           = fifo_empty_i ? '0 : fifo_data_i[ELEM_MAX-1:0];
                len            = elem_bits(st_d.phase ? wid2_i : wid1_i);
                aligned        = word << (6'(ELEM_MAX) - len);
                st_d.sd        = aligned[ELEM_MAX-1];
                st_d.sh        = aligned << 1;
                st_d.bits_left = BIT_W'(len - 6'd1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_o       = st_q.sd;
    assign busy_o     = (st_q.state != S_IDLE);
    assign underrun_o = st_q.udr;
    assign fs_err_o   = st_q.fserr;

    // R5: the line stays low during the lead-in
    a_r5_delay_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == S_DELAY) |-> !st_q.sd);

    // R7: an idle transmitter drives zero
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !sd_o);

    // R7: nothing moves between launch ticks
    a_r7_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state != S_IDLE && !tick_i) |=> ($stable(st_q.state) && $stable(st_q.sd)));

    // R9: an underrun pulse follows a load from an empty store
    a_r9_underrun_from_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.udr |-> $past(fifo_empty_i));

    // R10: a sync error is only reported for an edge inside a frame
    a_r10_fserr_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.fserr |-> ($past(st_q.state) != S_IDLE));

endmodule

// File: rtl/dpf_serializer.sv
module dpf_serializer #(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 16,
    parameter int FLEN_W     = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bclk_i,
    input  logic              fs_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              dual_phase_i,
    input  logic [FLEN_W-1:0] p1_count_i,
    input  logic [FLEN_W-1:0] p2_count_i,
    input  logic [2:0]        p1_width_i,
    input  logic [2:0]        p2_width_i,
    input  logic [1:0]        delay_i,
    input  logic              launch_fall_i,
    input  logic              fs_low_i,
    output logic              sd_o,
    output logic              busy_o,
    output logic              fifo_empty_o,
    output logic              fifo_full_o,
    output logic              underrun_o,
    output logic              fs_err_o
);

    logic              tick, fs_edge, pop;
    logic [WORD_W-1:0] head;

    dpf_edge i_edge (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .bclk_i        (bclk_i),
        .fs_i          (fs_i),
        .launch_fall_i (launch_fall_i),
        .fs_low_i      (fs_low_i),
        .tick_o        (tick),
        .fs_edge_o     (fs_edge)
    );

    dpf_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_i      (pop),
        .rd_data_o (head),
        .empty_o   (fifo_empty_o),
        .full_o    (fifo_full_o)
    );

    dpf_framer #(
        .WORD_W (WORD_W),
        .FLEN_W (FLEN_W)
    ) i_framer (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .fs_edge_i    (fs_edge),
        .dual_i       (dual_phase_i),
        .cnt1_i       (p1_count_i),
        .cnt2_i       (p2_count_i),
        .wid1_i       (p1_width_i),
        .wid2_i       (p2_width_i),
        .delay_i      (delay_i),
        .fifo_data_i  (head),
        .fifo_empty_i (fifo_empty_o),
        .pop_o        (pop),
        .sd_o         (sd_o),
        .busy_o       (busy_o),
        .underrun_o   (underrun_o),
        .fs_err_o     (fs_err_o)
    );

endmodule

// File: tb/test_dpf_serializer.sv
module test_dpf_serializer;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fs = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        dual = 1'b0;
    logic [5:0]  cnt1 = '0, cnt2 = '0;
    logic [2:0]  wid1 = '0, wid2 = '0;
    logic [1:0]  dly = '0;
    logic        lfall = 1'b0, fslow = 1'b0;
    logic        sd, busy, fempty, ffull, udr, fserr;

    int n_chk = 0, n_fail = 0;
    int udr_seen = 0, fse_seen = 0;
    bit done = 1'b0;

    logic [31:0] model_q[$];
    bit          exp_sd[$];
    bit          exp_fs[$];

    always #(CLK_P/2) clk = ~clk;

    dpf_serializer i_dpf_serializer (
        .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fs_i(fs),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .dual_phase_i(dual),
        .p1_count_i(cnt1), .p2_count_i(cnt2), .p1_width_i(wid1), .p2_width_i(wid2),
        .delay_i(dly), .launch_fall_i(lfall), .fs_low_i(fslow),
        .sd_o(sd), .busy_o(busy), .fifo_empty_o(fempty), .fifo_full_o(ffull),
        .underrun_o(udr), .fs_err_o(fserr)
    );

    always @(negedge clk) begin
        if (udr) udr_seen++;
        if (fserr) fse_seen++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int width_of(input int code);
        int w;
        case (code)
            0: w = 8;   1: w = 10;  2: w = 12;  3: w = 14;
            4: w = 16;  5: w = 20;  6: w = 24;  default: w = 32;
        endcase
        return w;
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        if (model_q.size() < DEPTH) model_q.push_back(w);
    endtask

    task automatic set_cfg(input bit dp, input int c1, input int c2, input int w1,
                           input int w2, input int d, input bit lf, input bit fl);
        @(negedge clk);
        dual  = dp;
        cnt1  = 6'(c1 - 1);
        cnt2  = 6'(c2 - 1);
        wid1  = 3'(w1);
        wid2  = 3'(w2);
        dly   = 2'(d);
        lfall = lf;
        fslow = fl;
        fs    = fl;
    endtask

    // one bit slot: non-launch edge, launch edge with fs, then sample
    task automatic slot(input bit fs_act, output bit sdv, output bit bv);
        @(negedge clk);
        bclk = lfall;
        repeat (2) @(negedge clk);
        bclk = ~lfall;
        fs   = fs_act ^ fslow;
        repeat (2) @(negedge clk);
        sdv = sd;
        bv  = busy;
    endtask

    task automatic append_frame(inout int udr_exp);
        int start;
        start = exp_sd.size();
        for (int k = 0; k < int'(dly); k++) begin
            exp_sd.push_back(1'b0);
            exp_fs.push_back(1'b0);
        end
        for (int p = 0; p < (dual ? 2 : 1); p++) begin
            int c, l;
            c = (p == 0) ? int'(cnt1) + 1 : int'(cnt2) + 1;
            l = width_of((p == 0) ? int'(wid1) : int'(wid2));
            for (int e = 0; e < c; e++) begin
                logic [31:0] w;
                if (model_q.size() > 0) w = model_q.pop_front();
                else begin w = '0; udr_exp++; end
                for (int b = l - 1; b >= 0; b--) begin
                    exp_sd.push_back(w[b]);
                    exp_fs.push_back(1'b0);
                end
            end
        end
        exp_fs[start] = 1'b1;
    endtask

    task automatic run_frames(input int nf, input bit inj, input string tag);
        int udr_exp, u0, f0, injk, last;
        bit sdv, bv;
        exp_sd.delete();
        exp_fs.delete();
        udr_exp = 0;
        for (int f = 0; f < nf; f++) append_frame(udr_exp);
        exp_sd.push_back(1'b0);
        exp_fs.push_back(1'b0);
        u0   = udr_seen;
        f0   = fse_seen;
        injk = inj ? int'(dly) + 3 : -1;
        last = exp_sd.size() - 1;
        for (int k = 0; k <= last; k++) begin
            slot(exp_fs[k] || (k == injk), sdv, bv);
            chk(sdv == exp_sd[k], tag, int'(sdv), int'(exp_sd[k]));
            chk(bv == (k < last), "R7 busy", int'(bv), int'(k < last));
        end
        repeat (2) @(negedge clk);
        chk(udr_seen - u0 == udr_exp, "R9 underrun pulses", udr_seen - u0, udr_exp);
        chk(fse_seen - f0 == (inj ? 1 : 0), "R10 sync errors", fse_seen - f0, inj ? 1 : 0);
        chk(fempty == (model_q.size() == 0), "R8 empty flag", int'(fempty),
            int'(model_q.size() == 0));
    endtask

    initial begin
        int legal[6] = '{1, 2, 4, 8, 12, 16};
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(sd == 1'b0, "R7 reset sd", int'(sd), 0);
        chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
        chk(fempty == 1'b1, "R8 reset empty", int'(fempty), 1);
        chk(ffull == 1'b0, "R8 reset full", int'(ffull), 0);

        // R8: fill to full, one extra write is dropped
        set_cfg(0, 16, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) push_word(32'hA500_0000 + 32'(i * 37));
        chk(ffull == 1'b1, "R8 full flag", int'(ffull), 1);
        chk(fempty == 1'b0, "R8 not empty", int'(fempty), 0);
        run_frames(1, 0, "R4 drop-on-full stream");

        // R1: 1 x 16 bits then 12 x 20 bits, delay 1
        set_cfg(1, 1, 12, 4, 5, 1, 0, 0);
        for (int i = 0; i < 13; i++) push_word($urandom);
        run_frames(1, 0, "R1 two-phase stream");

        // R5: no lead-in
        set_cfg(0, 2, 1, 1, 0, 0, 0, 0);
        push_word(32'h0000_02C5);
        push_word(32'hFFFF_FD3A);
        run_frames(1, 0, "R5 zero delay stream");

        // R2 and R9: 64 elements of 8 bits with only 16 words stored
        set_cfg(0, 64, 1, 0, 0, 2, 0, 0);
        for (int i = 0; i < DEPTH; i++) push_word($urandom);
        run_frames(1, 0, "R2 max count stream");

        // R6: falling-edge launch, active-low sync, delay 3
        set_cfg(0, 4, 1, 2, 0, 3, 1, 1);
        for (int i = 0; i < 4; i++) push_word($urandom);
        run_frames(1, 0, "R6 falling/low stream");

        // R10: sync edge in mid-frame is ignored
        set_cfg(1, 2, 2, 3, 6, 1, 0, 0);
        for (int i = 0; i < 4; i++) push_word($urandom);
        run_frames(1, 1, "R10 mid-frame sync stream");

        // R10: back-to-back frames, sync on the tick after the last bit
        set_cfg(0, 2, 1, 0, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) push_word($urandom);
        run_frames(2, 0, "R10 back-to-back stream");

        // R3: random shapes
        for (int it = 0; it < 18; it++) begin
            int c1, c2, nf, need, sh;
            bit dp, inj;
            dp = $urandom % 2;
            c1 = legal[$urandom % 6];
            c2 = legal[$urandom % 6];
            while (dp && (c1 + c2 > DEPTH)) begin
                c1 = legal[$urandom % 4];
                c2 = legal[$urandom % 4];
            end
            set_cfg(dp, c1, c2, $urandom % 8, $urandom % 8, $urandom % 4,
                    $urandom % 2, $urandom % 2);
            nf   = ($urandom % 5 == 0) ? 2 : 1;
            inj  = (nf == 1) && ($urandom % 4 == 0);
            need = (c1 + (dp ? c2 : 0)) * nf;
            sh   = ($urandom % 4 == 0) ? int'($urandom % 3) : 0;
            need = need - sh;
            if (need > DEPTH) need = DEPTH;
            for (int i = 0; i < need; i++) push_word($urandom);
            run_frames(nf, inj, "R3 random stream");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule